// File: doc/BRIEF.md
# Multi-Slot Transmit Frame Buffer Controller

This block holds up to eight staged transmit frames for a timing protocol in a 2 KB byte-addressable buffer. The buffer is divided into eight fixed 256-byte slots. Software fills a slot over a simple register bus, then queues it by writing a one to that slot's send bit in a control register. The block keeps a waiting flag for each queued slot. It offers the lowest-numbered waiting slot to an external transmit arbiter through a request/grant handshake. Once granted, it streams the frame out one byte per cycle with valid and last markers.

Each slot starts with a two-byte big-endian length, and the frame bytes follow it. When a frame completes, the block clears that slot's waiting flag, records the slot number as the most recently sent, and raises an interrupt. Any access to the control register clears the interrupt. Software can poll the waiting flags instead of taking the interrupt.

Top module: `txb_ctrl`

## Requirements
- R1: After reset, the control register reads 0, and irq_o, arb_req_o and tx_valid_o are all low.
- R2: Bus offsets 0x1000 to 0x17FF map one byte each onto the 2 KB buffer. A write stores bus_wdata_i[7:0]. A read returns the byte in bus_rdata_o[7:0] with bits 31:8 zero, one cycle after the request, with bus_rvalid_o high.
- R3: The control register sits at offset 0x2000. On a read, bits 7:0 and 31:19 are always 0, bits 15:8 are the waiting flags of slots 7..0 (bit 8 is slot 0), and bits 18:16 hold the most recently sent slot.
- R4: Writing bus_wdata_i[k]=1 to the control register sets the waiting flag of slot k. A 0 in that bit, or a 1 for a slot that is already waiting, leaves the flags unchanged.
- R5: While any flag is set, arb_req_o is raised and held until arb_grant_i is sampled high. Only one frame is in flight at a time, and the lowest-numbered waiting slot goes first.
- R6: Slot k covers buffer bytes 256k to 256k+255. Byte 0 is the high length byte and byte 1 is the low length byte. The frame bytes start at offset 2. The first byte appears on tx_data_o with tx_valid_o on the fourth cycle after the grant edge. One byte follows per cycle, with tx_last_o on the final byte only.
- R7: A length field of 0 or greater than 254 sends 254 bytes.
- R8: In the cycle after the last byte, the slot's waiting flag is 0, bits 18:16 hold that slot, and irq_o is 1.
- R9: Any control register read or write clears irq_o. A completion in the same cycle wins.
- R10: Offsets outside the buffer and the control register read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 14 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| arb_req_o | output | 1 | Request to the transmit arbiter |
| arb_grant_i | input | 1 | Grant from the transmit arbiter |
| tx_data_o | output | 8 | Outgoing frame byte |
| tx_valid_o | output | 1 | Byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| irq_o | output | 1 | Frame sent interrupt |

## Verification
Read data is due one cycle after the request, so the bench samples bus_rdata_o on the falling edge that follows the request edge. After a grant edge, three header cycles pass with tx_valid_o low, and the bench checks each of them. It expects the first byte on the fourth falling edge and then one byte per cycle. The waiting flag, the last-slot field and irq_o are checked on the falling edge just after the final byte. Arbiter order is shown by the slot-specific byte pattern of each frame, and requests are held ungranted for several cycles to confirm that arb_req_o stays high.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int unsigned BUS_AW    = 14;
  localparam int unsigned BUS_DW    = 32;
  localparam logic [13:0] BUF_BASE  = 14'h1000;
  localparam logic [13:0] CTRL_ADDR = 14'h2000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_HDR0,
    ST_HDR1,
    ST_HDR2,
    ST_DATA
  } tx_state_e;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_BUF,
    RSEL_CTRL
  } rd_sel_e;
endpackage

// File: rtl/txb_mem.sv
module txb_mem #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [7:0]    a_wdata_i,
  output logic [7:0]    a_rdata_o,
  input  logic [AW-1:0] b_addr_i,
  output logic [7:0]    b_rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
    a_rdata_o <= mem_q[a_addr_i];
    b_rdata_o <= mem_q[b_addr_i];
  end
endmodule

// File: rtl/txb_sched.sv
module txb_sched #(
  parameter int unsigned N_SLOTS = 8,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] set_i,
  input  logic               ctrl_acc_i,
  input  logic               done_i,
  input  logic [SLOT_W-1:0]  done_slot_i,
  output logic [N_SLOTS-1:0] waiting_o,
  output logic [SLOT_W-1:0]  last_slot_o,
  output logic               irq_o,
  output logic               pend_any_o,
  output logic [SLOT_W-1:0]  pend_slot_o
);
  logic [N_SLOTS-1:0] waiting_q, waiting_d, done_mask;
  logic [SLOT_W-1:0]  last_q;
  logic               irq_q;

  always_comb begin
    done_mask = '0;
    if (done_i) done_mask[done_slot_i] = 1'b1;
    // a set for an already waiting slot is absorbed by the OR
    waiting_d = (waiting_q | set_i) & ~done_mask;
  end

  always_comb begin
    pend_slot_o = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (waiting_q[i]) pend_slot_o = SLOT_W'(i);
    end
  end

  assign pend_any_o = |waiting_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q <= '0;
      last_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      waiting_q <= waiting_d;
      if (done_i) last_q <= done_slot_i;
      if (done_i)          irq_q <= 1'b1;
      else if (ctrl_acc_i) irq_q <= 1'b0;
    end
  end

  assign waiting_o   = waiting_q;
  assign last_slot_o = last_q;
  assign irq_o       = irq_q;

  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> irq_q); // R8
  AST_WAIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !waiting_q[$past(done_slot_i)]); // R8
  AST_IRQ_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_acc_i && !done_i) |=> !irq_q); // R9
  AST_PICK_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_any_o |-> (waiting_q[pend_slot_o] &&
                    ((waiting_q & ((N_SLOTS'(1) << pend_slot_o) - N_SLOTS'(1))) == '0))); // R5
endmodule

// File: rtl/txb_stream.sv
module txb_stream
  import txb_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned SLOT_AW = 8,
  parameter int unsigned MAX_LEN = 254,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS),
  localparam int unsigned MEM_AW = SLOT_W + SLOT_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_any_i,
  input  logic [SLOT_W-1:0] pend_slot_i,
  output logic              arb_req_o,
  input  logic              arb_grant_i,
  output logic [MEM_AW-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] done_slot_o
);
  tx_state_e          state_q, state_d;
  logic [SLOT_W-1:0]  slot_q;
  logic [7:0]         hi_q;
  logic [SLOT_AW-1:0] len_q, cnt_q;
  logic [15:0]        raw_len;
  logic [SLOT_AW-1:0] len_clamped;
  logic               last_byte;

  assign raw_len     = {hi_q, rd_data_i};
  assign len_clamped = (raw_len == 16'd0 || raw_len > 16'(MAX_LEN))
                       ? SLOT_AW'(MAX_LEN) : raw_len[SLOT_AW-1:0];
  assign last_byte   = (cnt_q == len_q - SLOT_AW'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (pend_any_i) state_d = ST_REQ;
      ST_REQ:  if (arb_grant_i) state_d = ST_HDR0;
      ST_HDR0: state_d = ST_HDR1;
      ST_HDR1: state_d = ST_HDR2;
      ST_HDR2: state_d = ST_DATA;
      ST_DATA: if (last_byte) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_HDR1: rd_addr_o = {slot_q, SLOT_AW'(1)};
      ST_HDR2: rd_addr_o = {slot_q, SLOT_AW'(2)};
      ST_DATA: rd_addr_o = {slot_q, SLOT_AW'(cnt_q + SLOT_AW'(3))};
      default: rd_addr_o = {slot_q, SLOT_AW'(0)};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      hi_q    <= '0;
      len_q   <= SLOT_AW'(1);
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && pend_any_i) slot_q <= pend_slot_i;
      if (state_q == ST_HDR1) hi_q <= rd_data_i;
      if (state_q == ST_HDR2) begin
        len_q <= len_clamped;
        cnt_q <= '0;
      end else if (state_q == ST_DATA) begin
        cnt_q <= cnt_q + SLOT_AW'(1);
      end
    end
  end

  assign arb_req_o   = (state_q == ST_REQ);
  assign tx_valid_o  = (state_q == ST_DATA);
  assign tx_data_o   = tx_valid_o ? rd_data_i : 8'h00;
  assign tx_last_o   = tx_valid_o && last_byte;
  assign done_o      = tx_last_o;
  assign done_slot_o = slot_q;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_req_o && !arb_grant_i) |=> arb_req_o); // R5
  AST_NO_REQ_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !arb_req_o); // R5
  AST_LAST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o); // R6
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (len_q >= SLOT_AW'(1) && len_q <= SLOT_AW'(MAX_LEN))); // R7
  AST_SLOT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_last_o) |=> $stable(slot_q)); // R5
endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl
  import txb_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned SLOT_AW = 8,
  parameter int unsigned MAX_LEN = 254,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS),
  localparam int unsigned MEM_AW = SLOT_W + SLOT_AW,
  localparam int unsigned WAIT_LSB = N_SLOTS,
  localparam int unsigned LAST_LSB = 2 * N_SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              arb_req_o,
  input  logic              arb_grant_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  output logic              irq_o
);
  localparam logic [BUS_AW-1:0] BUF_END = BUF_BASE + BUS_AW'((1 << MEM_AW) - 1);

  logic               buf_hit, ctrl_hit, ctrl_acc, buf_we;
  logic [MEM_AW-1:0]  buf_addr, tx_addr;
  logic [7:0]         buf_rdata, tx_rdata;
  logic [N_SLOTS-1:0] set_mask, waiting;
  logic [SLOT_W-1:0]  last_slot, pend_slot, done_slot;
  logic               pend_any, done;
  logic [BUS_DW-1:0]  ctrl_view, ctrl_snap_q;
  rd_sel_e            rsel_q;
  logic               rvalid_q;

  assign buf_hit  = (bus_addr_i >= BUF_BASE) && (bus_addr_i <= BUF_END);
  assign ctrl_hit = (bus_addr_i == CTRL_ADDR);
  assign ctrl_acc = bus_req_i && ctrl_hit;
  assign buf_we   = bus_req_i && bus_we_i && buf_hit;
  assign buf_addr = MEM_AW'(bus_addr_i - BUF_BASE);
  assign set_mask = (ctrl_acc && bus_we_i) ? bus_wdata_i[N_SLOTS-1:0] : '0;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[WAIT_LSB +: N_SLOTS] = waiting;
    ctrl_view[LAST_LSB +: SLOT_W]  = last_slot;
  end

  txb_mem #(.AW(MEM_AW)) u_mem (
    .clk_i     (clk_i),
    .a_we_i    (buf_we),
    .a_addr_i  (buf_addr),
    .a_wdata_i (bus_wdata_i[7:0]),
    .a_rdata_o (buf_rdata),
    .b_addr_i  (tx_addr),
    .b_rdata_o (tx_rdata)
  );

  txb_sched #(.N_SLOTS(N_SLOTS)) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_mask),
    .ctrl_acc_i  (ctrl_acc),
    .done_i      (done),
    .done_slot_i (done_slot),
    .waiting_o   (waiting),
    .last_slot_o (last_slot),
    .irq_o       (irq_o),
    .pend_any_o  (pend_any),
    .pend_slot_o (pend_slot)
  );

  txb_stream #(
    .N_SLOTS (N_SLOTS),
    .SLOT_AW (SLOT_AW),
    .MAX_LEN (MAX_LEN)
  ) u_stream (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_any_i  (pend_any),
    .pend_slot_i (pend_slot),
    .arb_req_o   (arb_req_o),
    .arb_grant_i (arb_grant_i),
    .rd_addr_o   (tx_addr),
    .rd_data_i   (tx_rdata),
    .tx_data_o   (tx_data_o),
    .tx_valid_o  (tx_valid_o),
    .tx_last_o   (tx_last_o),
    .done_o      (done),
    .done_slot_o (done_slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_q      <= RSEL_NONE;
      rvalid_q    <= 1'b0;
      ctrl_snap_q <= '0;
    end else begin
      rvalid_q <= bus_req_i && !bus_we_i;
      if (bus_req_i && !bus_we_i) begin
        rsel_q      <= buf_hit ? RSEL_BUF : (ctrl_hit ? RSEL_CTRL : RSEL_NONE);
        ctrl_snap_q <= ctrl_view;
      end
    end
  end

  always_comb begin
    unique case (rsel_q)
      RSEL_BUF:  bus_rdata_o = {{(BUS_DW-8){1'b0}}, buf_rdata};
      RSEL_CTRL: bus_rdata_o = ctrl_snap_q;
      default:   bus_rdata_o = '0;
    endcase
  end
  assign bus_rvalid_o = rvalid_q;

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && ctrl_hit) |=>
      (bus_rdata_o[N_SLOTS-1:0] == '0 && bus_rdata_o[BUS_DW-1:LAST_LSB+SLOT_W] == '0)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && !ctrl_hit && !buf_hit) |=> (bus_rdata_o == '0)); // R10
  AST_RVALID_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i) |=> bus_rvalid_o); // R2
endmodule

// File: tb/tb_txb_ctrl.sv
`timescale 1ns/1ps
module tb_txb_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, grant = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, arb_req, tx_valid, tx_last, irq;
  logic [7:0]  tx_data;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  txb_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .arb_req_o(arb_req), .arb_grant_i(grant),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    chk("R2 rvalid", 32'(rvalid), 32'd1);
    d = rdata;
  endtask

  function automatic logic [7:0] pat(input int slot, input int i);
    return 8'(slot * 37 + i * 3 + 1);
  endfunction

  task automatic load_slot(input int slot, input logic [15:0] len_field, input int n);
    logic [13:0] base = 14'h1000 + 14'(slot * 256);
    bus_wr(base, 32'(len_field[15:8]));
    bus_wr(base + 14'd1, 32'(len_field[7:0]));
    for (int i = 0; i < n; i++) bus_wr(base + 14'(2 + i), 32'(pat(slot, i)));
  endtask

  // grant the pending request and check the frame of the expected slot
  task automatic serve(input int slot, input int n, input logic [7:0] wait_after);
    logic [31:0] r;
    int guard = 0;
    while (!arb_req && guard < 20) begin @(negedge clk); guard++; end
    chk("R5 request raised", 32'(arb_req), 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 request held without grant", 32'(arb_req), 32'd1);
    chk("R5 no data before grant", 32'(tx_valid), 32'd0);
    grant = 1'b1;
    @(negedge clk); grant = 1'b0;
    chk("R6 header cycle 1", 32'(tx_valid), 32'd0);
    @(negedge clk); chk("R6 header cycle 2", 32'(tx_valid), 32'd0);
    @(negedge clk); chk("R6 header cycle 3", 32'(tx_valid), 32'd0);
    chk("R5 request dropped after grant", 32'(arb_req), 32'd0);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk("R6 valid", 32'(tx_valid), 32'd1);
      chk("R6 data", 32'(tx_data), 32'(pat(slot, i)));
      chk("R6 last", 32'(tx_last), 32'(i == n - 1));
      @(negedge clk);
    end
    chk("R6 valid ends", 32'(tx_valid), 32'd0);
    chk("R8 irq raised", 32'(irq), 32'd1);
    bus_rd(14'h2000, r);
    chk("R8 waiting and last slot", r, {13'd0, 3'(slot), wait_after, 8'd0});
    chk("R9 irq cleared by read", 32'(irq), 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 arb_req", 32'(arb_req), 32'd0);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);
    bus_rd(14'h2000, r);
    chk("R1 ctrl reset", r, 32'd0);
  endtask

  task automatic t_buffer;
    logic [31:0] r;
    bus_wr(14'h1000, 32'hFFFF_FF5A);
    bus_wr(14'h17FF, 32'h0000_00C3);
    bus_wr(14'h10FF, 32'h0000_0011);
    bus_rd(14'h1000, r); chk("R2 first byte", r, 32'h5A);
    bus_rd(14'h17FF, r); chk("R2 last byte", r, 32'hC3);
    bus_rd(14'h10FF, r); chk("R2 slot edge", r, 32'h11);
    bus_wr(14'h1800, 32'h77);
    bus_rd(14'h1800, r); chk("R10 unmapped read", r, 32'd0);
    bus_rd(14'h1000, r); chk("R10 buffer untouched", r, 32'h5A);
    bus_wr(14'h2000, 32'h0);
    bus_rd(14'h2000, r); chk("R4 zero write no queue", r, 32'd0);
    chk("R4 no request", 32'(arb_req), 32'd0);
  endtask

  task automatic t_single;
    load_slot(3, 16'd5, 5);
    bus_wr(14'h2000, 32'h08);
    serve(3, 5, 8'h00);
  endtask

  task automatic t_priority;
    logic [31:0] r;
    load_slot(7, 16'd2, 2);
    load_slot(2, 16'd4, 4);
    load_slot(5, 16'd1, 1);
    bus_wr(14'h2000, 32'hA4);
    bus_rd(14'h2000, r); chk("R3 waiting flags", r, {13'd0, 3'd3, 8'hA4, 8'd0});
    bus_wr(14'h2000, 32'h04);
    bus_wr(14'h2000, 32'h00);
    bus_rd(14'h2000, r); chk("R4 repeat and zero writes ignored", r, {13'd0, 3'd3, 8'hA4, 8'd0});
    serve(2, 4, 8'hA0);
    serve(5, 1, 8'h80);
    serve(7, 2, 8'h00);
    repeat (4) @(negedge clk);
    chk("R4 no requeue of repeated bit", 32'(arb_req), 32'd0);
  endtask

  task automatic t_clamp;
    load_slot(6, 16'h012C, 254);
    bus_wr(14'h2000, 32'h40);
    serve(6, 254, 8'h00);
    bus_wr(14'h1100, 32'h00);
    bus_wr(14'h1101, 32'h00);
    for (int i = 0; i < 254; i++) bus_wr(14'h1102 + 14'(i), 32'(pat(1, i)));
    bus_wr(14'h2000, 32'h02);
    serve(1, 254, 8'h00);
  endtask

  task automatic t_irq_write_clear;
    load_slot(0, 16'd3, 3);
    bus_wr(14'h2000, 32'h01);
    serve(0, 3, 8'h00);
    load_slot(4, 16'd1, 1);
    bus_wr(14'h2000, 32'h10);
    while (!arb_req) @(negedge clk);
    grant = 1'b1; @(negedge clk); grant = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 irq after frame", 32'(irq), 32'd1);
    bus_wr(14'h2000, 32'h00);
    chk("R9 irq cleared by write", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_buffer();
    t_single();
    t_priority();
    t_clamp();
    t_irq_write_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule